// File: doc/BRIEF.md
# PPP/HDLC Transmit Frame Encapsulator

This block turns a byte-wide packet stream into framed PPP/HDLC bytes. Between frames it sends flag bytes without a break. When a packet is waiting and enough flags have gone out since the last frame, it starts a frame. The frame holds, in order, an optional address byte and control byte, an optional protocol field of one or two bytes taken from configuration, the packet bytes, and a frame check sequence. The closing flag also counts as the first flag of the next gap.

The output runs at one byte per clock. Beside each byte is a mark that tells the downstream octet-stuffing stage which bytes are delimiters, meaning flags and abort escapes, and so must not be escaped. An error-force input corrupts or aborts the frame in progress. Which of the two it does is set by configuration. Diagnostic XOR masks can alter the address, control and protocol bytes as they are sent.

The packet source is expected to hold a whole packet, so that once the first byte of a packet is accepted, valid stays high through the end marker. Configuration is expected to change only while flags are being sent.

Top module: `ppp_frame_tx`

## Requirements
- R1: After reset, and whenever no packet is waiting, every output byte equals `cfg_flag` with `out_is_delim` = 1.
- R2: Consecutive frames from back-to-back packets are separated by exactly max(`cfg_min_flags`,1) flag bytes, the closing flag included; a frame never starts before that many flags have been sent.
- R3: With `cfg_acfc` = 0, the first two frame bytes are `cfg_addr ^ cfg_addr_mask` followed by `cfg_ctrl ^ cfg_ctrl_mask`.
- R4: With `cfg_acfc` = 1, no address or control byte is sent.
- R5: With `cfg_proto_int` = 1, the protocol bytes follow the address and control position, XORed with `cfg_proto_mask`: for `cfg_proto_two` = 1, bits [15:8] are sent and then bits [7:0]; for `cfg_proto_two` = 0, only bits [7:0] are sent.
- R6: With `cfg_proto_int` = 0, no protocol byte is inserted, and the packet bytes carry the protocol field themselves.
- R7: Packet bytes are sent unchanged and in order. A byte offered without `in_sof` while no frame is active is accepted and discarded.
- R8: With `cfg_fcs32` = 0, the FCS is 2 bytes. It is a CRC-16 (generator x^16+x^12+x^5+1, processed LSB first, register preset to all ones) over every frame byte between the flags. It is sent complemented, low byte first.
- R9: With `cfg_fcs32` = 1, the FCS is 4 bytes. It is the standard CRC-32 (reflected, preset to all ones), sent complemented, low byte first.
- R10: If `force_err` is high in any cycle from the first frame byte through the end-marker cycle and `cfg_err_abort` = 0, every FCS byte is the bitwise inverse of the correct one.
- R11: Under the same condition with `cfg_err_abort` = 1, no FCS is sent. After the last packet byte the block sends `cfg_esc` with `out_is_delim` = 1, then a flag.
- R12: `force_err` while no frame is active has no effect on the next frame.
- R13: `out_is_delim` is 1 exactly on flag bytes and on the abort escape byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Packet byte offered |
| in_data | input | 8 | Packet byte |
| in_sof | input | 1 | Byte is the first of a packet |
| in_eof | input | 1 | Byte is the last of a packet |
| in_ready | output | 1 | Offered byte is taken this cycle |
| force_err | input | 1 | Corrupt or abort the frame in progress |
| cfg_flag | input | 8 | Flag byte value |
| cfg_min_flags | input | GAP_W | Minimum flags between frames (0 acts as 1) |
| cfg_addr | input | 8 | Address byte |
| cfg_ctrl | input | 8 | Control byte |
| cfg_acfc | input | 1 | Omit address and control |
| cfg_proto_int | input | 1 | Insert protocol field from configuration |
| cfg_proto_two | input | 1 | Inserted protocol field is two bytes |
| cfg_proto | input | 16 | Protocol field value |
| cfg_addr_mask | input | 8 | XOR mask on address byte |
| cfg_ctrl_mask | input | 8 | XOR mask on control byte |
| cfg_proto_mask | input | 16 | XOR mask on protocol field |
| cfg_fcs32 | input | 1 | 1: CRC-32, 0: CRC-16 |
| cfg_err_abort | input | 1 | 1: error-force aborts, 0: corrupts FCS |
| cfg_esc | input | 8 | Escape byte used to abort |
| out_data | output | 8 | Output byte, one per cycle |
| out_is_delim | output | 1 | Output byte is a flag or abort escape |

## Verification
The bench sends back-to-back packets with minimum gaps of 0, 1 and larger. A design that miscounts the closing flag would show one flag too many or too few, and one that treats 0 literally would run frames together with no flag between them. Each header layout (compression on or off, one or two internal protocol bytes, protocol carried in the data) is tried with non-zero masks and both CRC widths. A wrong field order, a mask left out, or the CRC missing the header bytes would each show up as a byte mismatch. The bench also offers stray bytes without a start marker and pulses the error-force input while idle, which must not change the next frame. Forced errors are tried in both modes, and a block that ignored the mode would send an FCS where an escape and flag belong, or the reverse.

// File: rtl/ppp_tx_pkg.sv
// Shared types and the CRC step for the PPP/HDLC transmit encapsulator.
// Assumes reflected (LSB-first) CRC processing, as used on HDLC links.
package ppp_tx_pkg;
    localparam int BYTE_W = 8;
    localparam int CRC_W = 32;
    localparam int FCS_MAX = CRC_W / BYTE_W;
    localparam int FCS_IDX_W = $clog2(FCS_MAX);
    localparam logic [CRC_W-1:0] POLY32 = 32'hEDB8_8320;
    localparam logic [CRC_W-1:0] POLY16 = 32'h0000_8408;
    localparam logic [CRC_W-1:0] PRESET32 = 32'hFFFF_FFFF;
    localparam logic [CRC_W-1:0] PRESET16 = 32'h0000_FFFF;

    typedef enum logic [2:0] {
        ST_FLAG, ST_ADDR, ST_CTRL, ST_PHI, ST_PLO, ST_DATA, ST_FCS, ST_ABORT
    } tx_st_e;

    // Advances a reflected CRC by one byte; 16-bit mode keeps the upper half zero.
    function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c,
                                                  input logic [BYTE_W-1:0] b,
                                                  input logic wide);
        logic [CRC_W-1:0] r;
        r = c ^ {{(CRC_W-BYTE_W){1'b0}}, b};
        for (int i = 0; i < BYTE_W; i++) begin
            r = r[0] ? ((r >> 1) ^ (wide ? POLY32 : POLY16)) : (r >> 1);
        end
        return r;
    endfunction
endpackage

// File: rtl/ppp_tx_seq.sv
// Frame sequencer: walks flag gap, header fields, payload and FCS/abort tail.
// Assumes a started packet keeps in_valid high until its end marker, and
// configuration is static while a frame is in progress.
module ppp_tx_seq
    import ppp_tx_pkg::*;
#(
    parameter int GAP_W = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic                 in_sof,
    input  logic                 in_eof,
    input  logic                 force_err,
    input  logic [GAP_W-1:0]     cfg_min_flags,
    input  logic                 cfg_acfc,
    input  logic                 cfg_proto_int,
    input  logic                 cfg_proto_two,
    input  logic                 cfg_fcs32,
    input  logic                 cfg_err_abort,
    output tx_st_e               st,
    output logic [FCS_IDX_W-1:0] fcs_idx,
    output logic                 corrupt,
    output logic                 in_ready,
    output logic                 crc_init,
    output logic                 crc_en
);
    localparam logic [GAP_W-1:0] GAP_SAT = {GAP_W{1'b1}};

    tx_st_e             st_q, st_d;
    logic [GAP_W-1:0]   gap_q;
    logic [GAP_W:0]     gap_next, min_eff;
    logic               err_q, in_frame, go, eof_acc, err_hit;
    logic [FCS_IDX_W-1:0] fcs_last;

    // Gap, start and error qualification.
    always_comb begin
        min_eff  = (cfg_min_flags == '0) ? (GAP_W+1)'(1) : {1'b0, cfg_min_flags};
        gap_next = {1'b0, gap_q} + (GAP_W+1)'(1);
        go       = (st_q == ST_FLAG) && in_valid && in_sof && (gap_next >= min_eff);
        in_frame = (st_q == ST_ADDR) || (st_q == ST_CTRL) || (st_q == ST_PHI)
                || (st_q == ST_PLO) || (st_q == ST_DATA);
        eof_acc  = (st_q == ST_DATA) && in_valid && in_eof;
        err_hit  = err_q || (in_frame && force_err);
        fcs_last = cfg_fcs32 ? FCS_IDX_W'(FCS_MAX - 1) : FCS_IDX_W'(1);
    end

    // Next-state selection.
    always_comb begin
        st_d = st_q;
        case (st_q)
            ST_FLAG:  if (go) st_d = !cfg_acfc ? ST_ADDR
                                   : cfg_proto_int ? (cfg_proto_two ? ST_PHI : ST_PLO) : ST_DATA;
            ST_ADDR:  st_d = ST_CTRL;
            ST_CTRL:  st_d = cfg_proto_int ? (cfg_proto_two ? ST_PHI : ST_PLO) : ST_DATA;
            ST_PHI:   st_d = ST_PLO;
            ST_PLO:   st_d = ST_DATA;
            ST_DATA:  if (eof_acc) st_d = (err_hit && cfg_err_abort) ? ST_ABORT : ST_FCS;
            ST_FCS:   if (fcs_idx == fcs_last) st_d = ST_FLAG;
            default:  st_d = ST_FLAG;
        endcase
    end

    // State, gap counter, FCS byte index and error latch registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= ST_FLAG;
            gap_q   <= '0;
            fcs_idx <= '0;
            err_q   <= 1'b0;
        end else begin
            st_q    <= st_d;
            if (st_q != ST_FLAG || go) gap_q <= '0;
            else if (gap_q != GAP_SAT) gap_q <= gap_q + 1'b1;
            fcs_idx <= (st_q == ST_FCS) ? fcs_idx + 1'b1 : '0;
            if (st_q == ST_FLAG) err_q <= 1'b0;
            else if (in_frame && force_err) err_q <= 1'b1;
        end
    end

    // Handshake and CRC control derived from the current state.
    always_comb begin
        st       = st_q;
        in_ready = (st_q == ST_DATA) || ((st_q == ST_FLAG) && !in_sof);
        crc_init = (st_q == ST_FLAG);
        crc_en   = in_frame && ((st_q != ST_DATA) || in_valid);
        corrupt  = err_q && !cfg_err_abort;
    end
endmodule

// File: rtl/ppp_tx_fcs.sv
// FCS accumulator: preset on the flag state, advanced once per frame byte.
// Assumes the width select is static across a frame.
module ppp_tx_fcs
    import ppp_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init,
    input  logic              en,
    input  logic              wide,
    input  logic [BYTE_W-1:0] data,
    output logic [CRC_W-1:0]  crc
);
    // CRC register update.
    always_ff @(posedge clk) begin
        if (!rst_n || init) crc <= wide ? PRESET32 : PRESET16;
        else if (en)        crc <= crc_step(crc, data, wide);
    end
endmodule

// File: rtl/ppp_tx_outmux.sv
// Output byte selector: picks the flag, header field, payload, FCS byte or
// abort escape for the current state and marks delimiters.
module ppp_tx_outmux
    import ppp_tx_pkg::*;
(
    input  tx_st_e               st,
    input  logic [FCS_IDX_W-1:0] fcs_idx,
    input  logic                 corrupt,
    input  logic [CRC_W-1:0]     crc,
    input  logic [BYTE_W-1:0]    in_data,
    input  logic [BYTE_W-1:0]    cfg_flag,
    input  logic [BYTE_W-1:0]    cfg_addr,
    input  logic [BYTE_W-1:0]    cfg_ctrl,
    input  logic [2*BYTE_W-1:0]  cfg_proto,
    input  logic [BYTE_W-1:0]    cfg_addr_mask,
    input  logic [BYTE_W-1:0]    cfg_ctrl_mask,
    input  logic [2*BYTE_W-1:0]  cfg_proto_mask,
    input  logic [BYTE_W-1:0]    cfg_esc,
    output logic [BYTE_W-1:0]    out_data,
    output logic                 out_is_delim
);
    logic [CRC_W-1:0]       fcs_word;
    logic [2*BYTE_W-1:0]    proto_tx;

    // Byte selection per state.
    always_comb begin
        fcs_word     = corrupt ? crc : ~crc;
        proto_tx     = cfg_proto ^ cfg_proto_mask;
        out_is_delim = 1'b0;
        case (st)
            ST_ADDR:  out_data = cfg_addr ^ cfg_addr_mask;
            ST_CTRL:  out_data = cfg_ctrl ^ cfg_ctrl_mask;
            ST_PHI:   out_data = proto_tx[2*BYTE_W-1:BYTE_W];
            ST_PLO:   out_data = proto_tx[BYTE_W-1:0];
            ST_DATA:  out_data = in_data;
            ST_FCS:   out_data = fcs_word[{fcs_idx, 3'b000} +: BYTE_W];
            ST_ABORT: begin out_data = cfg_esc;  out_is_delim = 1'b1; end
            default:  begin out_data = cfg_flag; out_is_delim = 1'b1; end
        endcase
    end
endmodule

// File: rtl/ppp_frame_tx.sv
// PPP/HDLC transmit frame encapsulator top: one output byte per clock.
// Assumes whole packets are available at the input once started and that
// configuration changes only between frames.
module ppp_frame_tx
    import ppp_tx_pkg::*;
#(
    parameter int GAP_W = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [BYTE_W-1:0]   in_data,
    input  logic                in_sof,
    input  logic                in_eof,
    output logic                in_ready,
    input  logic                force_err,
    input  logic [BYTE_W-1:0]   cfg_flag,
    input  logic [GAP_W-1:0]    cfg_min_flags,
    input  logic [BYTE_W-1:0]   cfg_addr,
    input  logic [BYTE_W-1:0]   cfg_ctrl,
    input  logic                cfg_acfc,
    input  logic                cfg_proto_int,
    input  logic                cfg_proto_two,
    input  logic [2*BYTE_W-1:0] cfg_proto,
    input  logic [BYTE_W-1:0]   cfg_addr_mask,
    input  logic [BYTE_W-1:0]   cfg_ctrl_mask,
    input  logic [2*BYTE_W-1:0] cfg_proto_mask,
    input  logic                cfg_fcs32,
    input  logic                cfg_err_abort,
    input  logic [BYTE_W-1:0]   cfg_esc,
    output logic [BYTE_W-1:0]   out_data,
    output logic                out_is_delim
);
    tx_st_e               st;
    logic [FCS_IDX_W-1:0] fcs_idx;
    logic                 corrupt, crc_init, crc_en;
    logic [CRC_W-1:0]     crc;

    ppp_tx_seq #(.GAP_W(GAP_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
        .in_eof(in_eof), .force_err(force_err), .cfg_min_flags(cfg_min_flags),
        .cfg_acfc(cfg_acfc), .cfg_proto_int(cfg_proto_int),
        .cfg_proto_two(cfg_proto_two), .cfg_fcs32(cfg_fcs32),
        .cfg_err_abort(cfg_err_abort), .st(st), .fcs_idx(fcs_idx),
        .corrupt(corrupt), .in_ready(in_ready), .crc_init(crc_init),
        .crc_en(crc_en)
    );

    ppp_tx_fcs u_fcs (
        .clk(clk), .rst_n(rst_n), .init(crc_init), .en(crc_en),
        .wide(cfg_fcs32), .data(out_data), .crc(crc)
    );

    ppp_tx_outmux u_mux (
        .st(st), .fcs_idx(fcs_idx), .corrupt(corrupt), .crc(crc),
        .in_data(in_data), .cfg_flag(cfg_flag), .cfg_addr(cfg_addr),
        .cfg_ctrl(cfg_ctrl), .cfg_proto(cfg_proto),
        .cfg_addr_mask(cfg_addr_mask), .cfg_ctrl_mask(cfg_ctrl_mask),
        .cfg_proto_mask(cfg_proto_mask), .cfg_esc(cfg_esc),
        .out_data(out_data), .out_is_delim(out_is_delim)
    );
endmodule

// File: rtl/ppp_tx_chk.sv
// Protocol checker for the encapsulator, attached by bind.
module ppp_tx_chk
    import ppp_tx_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input tx_st_e               st,
    input logic [FCS_IDX_W-1:0] fcs_idx,
    input logic                 in_valid,
    input logic                 in_sof,
    input logic                 in_eof,
    input logic                 in_ready,
    input logic [BYTE_W-1:0]    out_data,
    input logic                 out_is_delim,
    input logic [BYTE_W-1:0]    cfg_flag,
    input logic                 cfg_acfc,
    input logic                 cfg_proto_int,
    input logic                 cfg_fcs32
);
    assert_idle_flag_R1: assert property (@(posedge clk) disable iff (!rst_n)
        st == ST_FLAG |-> (out_is_delim && out_data == cfg_flag));
    assert_acfc_skip_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_FLAG && !in_ready && in_valid) |=> (st != ST_ADDR || !cfg_acfc));
    assert_no_proto_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_PHI || st == ST_PLO) |-> cfg_proto_int);
    assert_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> (st == ST_DATA || (st == ST_FLAG && !in_sof)));
    assert_tail_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_DATA && in_valid && in_eof) |=> (st == ST_FCS || st == ST_ABORT));
    assert_fcs_len_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_FCS && fcs_idx > 1) |-> cfg_fcs32);
    assert_abort_close_R11: assert property (@(posedge clk) disable iff (!rst_n)
        st == ST_ABORT |=> (st == ST_FLAG && out_is_delim));
    assert_delim_R13: assert property (@(posedge clk) disable iff (!rst_n)
        out_is_delim |-> (st == ST_FLAG || st == ST_ABORT));
endmodule

bind ppp_frame_tx ppp_tx_chk u_chk (
    .clk(clk), .rst_n(rst_n), .st(st), .fcs_idx(fcs_idx), .in_valid(in_valid),
    .in_sof(in_sof), .in_eof(in_eof), .in_ready(in_ready), .out_data(out_data),
    .out_is_delim(out_is_delim), .cfg_flag(cfg_flag), .cfg_acfc(cfg_acfc),
    .cfg_proto_int(cfg_proto_int), .cfg_fcs32(cfg_fcs32)
);

// File: tb/ppp_frame_tx_test.sv
module ppp_frame_tx_test;
    logic clk = 0, rst_n = 0;
    logic in_valid = 0, in_sof = 0, in_eof = 0, force_err = 0;
    logic [7:0] in_data = 0;
    logic in_ready;
    logic [7:0] cfg_flag = 8'h7E, cfg_addr = 8'hFF, cfg_ctrl = 8'h03, cfg_esc = 8'h7D;
    logic [3:0] cfg_min_flags = 4'd1;
    logic cfg_acfc = 0, cfg_proto_int = 1, cfg_proto_two = 1, cfg_fcs32 = 0, cfg_err_abort = 0;
    logic [15:0] cfg_proto = 16'h0021, cfg_proto_mask = 0;
    logic [7:0] cfg_addr_mask = 0, cfg_ctrl_mask = 0;
    logic [7:0] out_data;
    logic out_is_delim;

    int checks = 0, errors = 0, cycles = 0;
    logic [7:0] exp_bytes[$];
    logic       exp_delim[$];
    int         exp_len[$];
    int         exp_gap[$];
    string      exp_tag[$];
    logic [7:0] got_b[$];
    logic       got_d[$];
    logic [7:0] pay[$];
    logic in_fr = 0;
    int gap = 0, start_gap = 0;

    always #2 clk = ~clk;

    ppp_frame_tx uut (.*);

    // Bit-serial reflected CRC reference.
    function automatic logic [31:0] ref_crc(input logic [31:0] c, input logic [7:0] b, input logic w);
        logic fb;
        for (int k = 0; k < 8; k++) begin
            fb = c[0] ^ b[k];
            c = c >> 1;
            if (fb) c = c ^ (w ? 32'hEDB88320 : 32'h00008408);
        end
        return c;
    endfunction

    // Expected frame from configuration and payload; mode 0 good, 1 corrupt, 2 abort.
    task automatic expect_frame(input int mode, input int g, input string tag);
        logic [7:0] fr[$];
        logic [31:0] c;
        int n;
        if (!cfg_acfc) begin fr.push_back(cfg_addr ^ cfg_addr_mask); fr.push_back(cfg_ctrl ^ cfg_ctrl_mask); end
        if (cfg_proto_int) begin
            if (cfg_proto_two) fr.push_back(cfg_proto[15:8] ^ cfg_proto_mask[15:8]);
            fr.push_back(cfg_proto[7:0] ^ cfg_proto_mask[7:0]);
        end
        foreach (pay[i]) fr.push_back(pay[i]);
        c = cfg_fcs32 ? 32'hFFFFFFFF : 32'h0000FFFF;
        foreach (fr[i]) c = ref_crc(c, fr[i], cfg_fcs32);
        n = fr.size();
        foreach (fr[i]) begin exp_bytes.push_back(fr[i]); exp_delim.push_back(1'b0); end
        if (mode == 2) begin
            exp_bytes.push_back(cfg_esc); exp_delim.push_back(1'b1); n = n + 1;
        end else begin
            if (mode == 0) c = ~c;
            for (int k = 0; k < (cfg_fcs32 ? 4 : 2); k++) begin
                exp_bytes.push_back(c[8*k +: 8]); exp_delim.push_back(1'b0); n = n + 1;
            end
        end
        exp_len.push_back(n); exp_gap.push_back(g); exp_tag.push_back(tag);
    endtask

    task automatic send_byte(input logic [7:0] d, input logic s, input logic e);
        logic acc;
        @(negedge clk);
        in_valid = 1; in_data = d; in_sof = s; in_eof = e;
        forever begin
            #1 acc = in_ready;
            @(posedge clk);
            if (acc) break;
            @(negedge clk);
        end
    endtask

    task automatic send_pkt(input int len, input int mode, input int g, input string tag);
        pay.delete();
        for (int i = 0; i < len; i++) pay.push_back(8'($urandom));
        expect_frame(mode, g, tag);
        cfg_err_abort = (mode == 2);
        force_err = (mode != 0);
        for (int i = 0; i < len; i++) send_byte(pay[i], i == 0, i == len - 1);
        @(negedge clk);
        in_valid = 0; in_sof = 0; in_eof = 0; force_err = 0;
    endtask

    task automatic drain();
        while (exp_len.size() != 0) @(negedge clk);
        repeat (20) @(negedge clk);
    endtask

    task automatic burst(input int npk, input int mode, input string tag);
        int mf;
        mf = (cfg_min_flags == 0) ? 1 : int'(cfg_min_flags);
        for (int p = 0; p < npk; p++) send_pkt(1 + ($urandom % 12), mode, (p == 0) ? -1 : mf, tag);
        drain();
    endtask

    // Output monitor: splits the stream into frames and gaps and compares.
    always @(negedge clk) begin
        #1;
        if (rst_n) begin
            if (out_is_delim && out_data == cfg_flag) begin
                if (in_fr) begin
                    int n, bad;
                    n = exp_len.pop_front();
                    bad = (got_b.size() != n);
                    for (int i = 0; i < n; i++) begin
                        logic [7:0] eb;
                        logic ed;
                        eb = exp_bytes.pop_front(); ed = exp_delim.pop_front();
                        if (i < got_b.size() && (got_b[i] !== eb || got_d[i] !== ed)) begin
                            if (!bad) $display("FAIL %s R13 byte %0d: actual %h/%b expected %h/%b",
                                               exp_tag[0], i, got_b[i], got_d[i], eb, ed);
                            bad = 1;
                        end
                    end
                    checks++;
                    if (bad) begin
                        errors++;
                        if (got_b.size() != n)
                            $display("FAIL %s frame length: actual %0d expected %0d", exp_tag[0], got_b.size(), n);
                    end
                    if (exp_gap[0] >= 0) begin
                        checks++;
                        if (start_gap != exp_gap[0]) begin
                            errors++;
                            $display("FAIL R2 flag gap: actual %0d expected %0d", start_gap, exp_gap[0]);
                        end
                    end
                    void'(exp_gap.pop_front()); void'(exp_tag.pop_front());
                    got_b.delete(); got_d.delete();
                    in_fr = 0; gap = 1;
                end else gap++;
            end else begin
                if (!in_fr) begin in_fr = 1; start_gap = gap; end
                got_b.push_back(out_data); got_d.push_back(out_is_delim);
            end
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++; checks++;
            $display("FAIL watchdog: actual %0d cycles expected under 150000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state and idle flags.
        for (int i = 0; i < 5; i++) begin
            @(negedge clk); #1;
            checks++;
            if (out_data !== 8'h7E || out_is_delim !== 1'b1) begin
                errors++;
                $display("FAIL R1 idle: actual %h/%b expected 7e/1", out_data, out_is_delim);
            end
        end
        // R3 R5 R8: default header, two-byte protocol, CRC-16, min gap 1.
        burst(4, 0, "R3 R5 R8");
        // R2: larger gap, masks on address/control/protocol.
        cfg_min_flags = 4'd3; cfg_addr_mask = 8'h0F; cfg_ctrl_mask = 8'hA0; cfg_proto_mask = 16'h8001;
        burst(4, 0, "R2 R3 R5");
        // R2: gap value 0 behaves as 1.
        cfg_min_flags = 4'd0;
        burst(3, 0, "R2");
        // R4 R5 R9: compression, one-byte protocol, CRC-32.
        cfg_min_flags = 4'd1; cfg_acfc = 1; cfg_proto_two = 0; cfg_fcs32 = 1;
        burst(4, 0, "R4 R5 R9");
        // R6: protocol carried in data.
        cfg_acfc = 0; cfg_proto_int = 0; cfg_fcs32 = 0;
        burst(3, 0, "R6 R8");
        // R7 R12: stray bytes and idle force pulse do not alter the next frame.
        @(negedge clk); force_err = 1;
        send_byte(8'h7E, 0, 0); send_byte(8'h11, 0, 1);
        @(negedge clk); in_valid = 0; in_eof = 0; force_err = 0;
        send_pkt(6, 0, -1, "R7 R12"); drain();
        // R10: corrupt mode, both widths.
        cfg_proto_int = 1; cfg_proto_two = 1;
        burst(2, 1, "R10");
        cfg_fcs32 = 1;
        burst(2, 1, "R10 R9");
        // R11: abort mode then a good frame.
        cfg_min_flags = 4'd2;
        burst(2, 2, "R11");
        send_pkt(5, 0, -1, "R11 recovery"); drain();
        // Random configurations.
        for (int ph = 0; ph < 8; ph++) begin
            cfg_flag = 8'($urandom); cfg_esc = cfg_flag ^ 8'h03;
            cfg_min_flags = 4'($urandom % 6);
            cfg_addr = 8'($urandom); cfg_ctrl = 8'($urandom);
            cfg_addr_mask = 8'($urandom); cfg_ctrl_mask = 8'($urandom);
            cfg_proto = 16'($urandom); cfg_proto_mask = 16'($urandom);
            cfg_acfc = 1'($urandom); cfg_proto_int = 1'($urandom);
            cfg_proto_two = 1'($urandom); cfg_fcs32 = 1'($urandom);
            repeat (4) @(negedge clk);
            gap = 0;
            burst(4, ph % 3, "R2 R3 R4 R5 R6 R8 R9 R10 R11");
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule